// File: doc/BRIEF.md
# Multi-Rate PHY Speed-Change Sequencer

This block moves a multi-rate Ethernet PHY between 1G, 2.5G, 5G and 10G operation. Software writes the wanted speed into a request register. The block then works through a fixed chain of steps, and each step starts only when the one before it has ended:

1. It sets the PHY mode output.
2. It streams a per-speed list of configuration words into the transceiver's configuration write port.
3. It selects the PLL that serves the new rate.
4. It fires a recalibration request and waits for the calibration engine to report completion.
5. It asks the reset controller to reset the PHY.

Software follows progress through a small status register that holds busy, done and error flags together with the active speed. The transceiver configuration port, the calibration engine and the reset controller are reached through plain request/acknowledge handshakes.

Top module: `phy_rate_switcher`

## Requirements
- R1: A write to register address 0 while the block is idle starts a sequence for the speed in write data bits [1:0]. `busy` rises on the cycle after the write. Without such a write the block stays idle and drives no handshake.
- R2: The first step sets `mode_sel` to the requested speed encoding (00=1G, 01=2.5G, 10=5G, 11=10G). This happens one cycle after the write is accepted and before any configuration word is offered.
- R3: The block offers exactly 8 configuration words, one per accepted handshake, with i counting from 0 to 7. Word i has address 0x40+i and data 0xA000 | (speed<<8) | i. `cfg_valid` and the offered word hold steady until `cfg_ready` is seen. The configuration, recalibration and reset requests are never active together.
- R4: `pll_sel` changes only after the last configuration word has been accepted. It is set to 0 for 1G and 2.5G, and to 1 for 5G and 10G.
- R5: After the PLL select, `recal_req` pulses for exactly one cycle. The block then waits, for as long as needed, until `recal_done` is seen.
- R6: After `recal_done`, `rst_req` goes high and stays high until `rst_ack` is seen.
- R7: `busy` stays high until the cycle after `rst_ack` is accepted. The sticky `done` flag is then set. A newly accepted request clears it, and so does writing 1 to status bit 1.
- R8: A speed request written while `busy` is high is ignored: the running sequence and `mode_sel` do not change. The request sets a sticky error flag, and writing 1 to status bit 2 clears it.
- R9: A request for the speed that is already active runs the full sequence again.
- R10: Register address 1 reads back as follows: bit 0 is busy, bit 1 is done, bit 2 is error, bits [5:4] are the current mode. After reset, `mode_sel`=00, `pll_sel`=0, all requests are low and the status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 request, 1 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| mode_sel | output | 2 | PHY speed mode |
| cfg_valid | output | 1 | Configuration word offered |
| cfg_ready | input | 1 | Transceiver accepts the word |
| cfg_addr | output | 8 | Configuration word address |
| cfg_data | output | 16 | Configuration word data |
| pll_sel | output | 1 | PLL select (0 low rates, 1 high rates) |
| recal_req | output | 1 | One-cycle recalibration request |
| recal_done | input | 1 | Calibration engine finished |
| rst_req | output | 1 | PHY reset request to the reset controller |
| rst_ack | input | 1 | Reset controller acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sticky completion flag |

## Verification
The bench uses the default parameters: 8 configuration words, 8-bit configuration addresses from base 0x40, and 16-bit data. These values keep each list short enough that every word can be compared against its expected value while the ready line stalls on alternate words. They also make every speed reachable in a few hundred cycles, which lets the bench cover each PLL transition in both directions, a repeat request for the same speed, and a request that lands during an open recalibration wait.

// File: rtl/prs_pkg.sv
package prs_pkg;

    typedef enum logic [1:0] {
        SPD_1G   = 2'b00,
        SPD_2G5  = 2'b01,
        SPD_5G   = 2'b10,
        SPD_10G  = 2'b11
    } speed_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MODE,
        ST_LOAD,
        ST_PLL,
        ST_CAL_REQ,
        ST_CAL_WAIT,
        ST_RST
    } seq_state_e;

    typedef struct packed {
        logic   start;
        speed_e speed;
    } req_t;

    typedef struct packed {
        logic [1:0] pad_hi;
        speed_e     mode;
        logic       pad_lo;
        logic       err;
        logic       done;
        logic       busy;
    } status_t;

    localparam logic [1:0] REG_SPEED  = 2'd0;
    localparam logic [1:0] REG_STATUS = 2'd1;

    // PLL 1 serves the two upper rates
    function automatic logic pll_for(input speed_e s);
        return s[1];
    endfunction

endpackage

// File: rtl/prs_cfg_table.sv
module prs_cfg_table
    import prs_pkg::*;
#(
    parameter int          WORDS = 8,
    parameter int          AW    = 8,
    parameter int          DW    = 16,
    parameter logic [AW-1:0] BASE = 8'h40,
    parameter logic [DW-1:0] TAG  = 16'hA000,
    localparam int         IW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  speed_e          speed,
    input  logic [IW-1:0]   idx,
    output logic [AW-1:0]   addr,
    output logic [DW-1:0]   data
);
    localparam int SPD_SHIFT = 8;

    logic [DW-1:0] spd_field;
    logic [DW-1:0] idx_field;

    always_comb begin
        spd_field = DW'(speed) << SPD_SHIFT;
        idx_field = DW'(idx);
    end

    generate
        if (AW > IW) begin : g_wide_addr
            assign addr = BASE + AW'(idx);
        end else begin : g_narrow_addr
            assign addr = BASE + idx[AW-1:0];
        end
    endgenerate

    assign data = TAG | spd_field | idx_field;

endmodule

// File: rtl/prs_regs.sv
module prs_regs
    import prs_pkg::*;
#(
    parameter int RAW = 2,
    parameter int RDW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_wr,
    input  logic [RAW-1:0] reg_addr,
    input  logic [RDW-1:0] reg_wdata,
    output logic [RDW-1:0] reg_rdata,
    input  logic           busy_i,
    input  logic           finish_i,
    input  speed_e         mode_i,
    output req_t           req_o,
    output logic           done_o,
    output logic           err_o
);
    logic   wr_speed;
    logic   wr_status;
    logic   done_q;
    logic   err_q;
    speed_e last_q;
    status_t st;

    always_comb begin
        wr_speed    = reg_wr && (reg_addr == RAW'(REG_SPEED));
        wr_status   = reg_wr && (reg_addr == RAW'(REG_STATUS));
        req_o.start = wr_speed && !busy_i;
        req_o.speed = speed_e'(reg_wdata[1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            last_q <= SPD_1G;
        end else begin
            if (req_o.start) begin
                done_q <= 1'b0;
                last_q <= req_o.speed;
            end else if (finish_i) begin
                done_q <= 1'b1;
            end else if (wr_status && reg_wdata[1]) begin
                done_q <= 1'b0;
            end

            if (wr_speed && busy_i) begin
                err_q <= 1'b1;
            end else if (wr_status && reg_wdata[2]) begin
                err_q <= 1'b0;
            end
        end
    end

    always_comb begin
        st        = '0;
        st.busy   = busy_i;
        st.done   = done_q;
        st.err    = err_q;
        st.mode   = mode_i;
        reg_rdata = '0;
        case (reg_addr)
            RAW'(REG_SPEED):  reg_rdata = RDW'(last_q);
            RAW'(REG_STATUS): reg_rdata = RDW'(st);
            default:          reg_rdata = '0;
        endcase
    end

    assign done_o = done_q;
    assign err_o  = err_q;

endmodule

// File: rtl/prs_seq.sv
module prs_seq
    import prs_pkg::*;
#(
    parameter int  WORDS = 8,
    localparam int IW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  req_t          req_i,
    input  logic          cfg_ready_i,
    input  logic          recal_done_i,
    input  logic          rst_ack_i,
    output logic          busy_o,
    output logic          finish_o,
    output speed_e        mode_o,
    output logic          pll_o,
    output logic          cfg_valid_o,
    output logic [IW-1:0] cfg_idx_o,
    output logic          recal_req_o,
    output logic          rst_req_o
);
    localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

    seq_state_e    state_q;
    speed_e        tgt_q;
    speed_e        mode_q;
    logic          pll_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tgt_q   <= SPD_1G;
            mode_q  <= SPD_1G;
            pll_q   <= 1'b0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_i.start) begin
                        tgt_q   <= req_i.speed;
                        state_q <= ST_MODE;
                    end
                end
                ST_MODE: begin
                    mode_q  <= tgt_q;
                    idx_q   <= '0;
                    state_q <= ST_LOAD;
                end
                ST_LOAD: begin
                    if (cfg_ready_i) begin
                        if (idx_q == LAST) begin
                            state_q <= ST_PLL;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_PLL: begin
                    pll_q   <= pll_for(tgt_q);
                    state_q <= ST_CAL_REQ;
                end
                ST_CAL_REQ: begin
                    state_q <= ST_CAL_WAIT;
                end
                ST_CAL_WAIT: begin
                    if (recal_done_i) begin
                        state_q <= ST_RST;
                    end
                end
                ST_RST: begin
                    if (rst_ack_i) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        cfg_valid_o = (state_q == ST_LOAD);
        recal_req_o = (state_q == ST_CAL_REQ);
        rst_req_o   = (state_q == ST_RST);
        finish_o    = (state_q == ST_RST) && rst_ack_i;
    end

    assign mode_o    = mode_q;
    assign pll_o     = pll_q;
    assign cfg_idx_o = idx_q;

endmodule

// File: rtl/phy_rate_switcher.sv
module phy_rate_switcher
    import prs_pkg::*;
#(
    parameter int               CFG_WORDS = 8,
    parameter int               CFG_AW    = 8,
    parameter int               CFG_DW    = 16,
    parameter logic [CFG_AW-1:0] CFG_BASE = 8'h40,
    parameter int               REG_AW    = 2,
    parameter int               REG_DW    = 8,
    localparam int              IW        = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic [1:0]        mode_sel,
    output logic              cfg_valid,
    input  logic              cfg_ready,
    output logic [CFG_AW-1:0] cfg_addr,
    output logic [CFG_DW-1:0] cfg_data,
    output logic              pll_sel,
    output logic              recal_req,
    input  logic              recal_done,
    output logic              rst_req,
    input  logic              rst_ack,
    output logic              busy,
    output logic              done
);
    req_t          req;
    logic          busy_w;
    logic          finish_w;
    speed_e        mode_w;
    logic [IW-1:0] idx_w;
    logic          err_w;

    prs_regs #(
        .RAW (REG_AW),
        .RDW (REG_DW)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy_i    (busy_w),
        .finish_i  (finish_w),
        .mode_i    (mode_w),
        .req_o     (req),
        .done_o    (done),
        .err_o     (err_w)
    );

    prs_seq #(
        .WORDS (CFG_WORDS)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req),
        .cfg_ready_i  (cfg_ready),
        .recal_done_i (recal_done),
        .rst_ack_i    (rst_ack),
        .busy_o       (busy_w),
        .finish_o     (finish_w),
        .mode_o       (mode_w),
        .pll_o        (pll_sel),
        .cfg_valid_o  (cfg_valid),
        .cfg_idx_o    (idx_w),
        .recal_req_o  (recal_req),
        .rst_req_o    (rst_req)
    );

    prs_cfg_table #(
        .WORDS (CFG_WORDS),
        .AW    (CFG_AW),
        .DW    (CFG_DW),
        .BASE  (CFG_BASE)
    ) u_table (
        .speed (mode_w),
        .idx   (idx_w),
        .addr  (cfg_addr),
        .data  (cfg_data)
    );

    assign mode_sel = mode_w;
    assign busy     = busy_w;

endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
    parameter int CFG_AW = 8,
    parameter int CFG_DW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode_sel,
    input logic              cfg_valid,
    input logic              cfg_ready,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [CFG_DW-1:0] cfg_data,
    input logic              pll_sel,
    input logic              recal_req,
    input logic              rst_req,
    input logic              rst_ack,
    input logic              busy,
    input logic              done
);
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_addr) && $stable(cfg_data)); // R3

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cfg_valid, recal_req, rst_req})); // R3

    AST_PLL_MATCH: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> pll_sel == mode_sel[1]); // R4

    AST_PLL_QUIET_LOAD: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |=> $stable(pll_sel)); // R4

    AST_RECAL_PULSE: assert property (@(posedge clk) disable iff (rst)
        recal_req |=> !recal_req); // R5

    AST_RST_HOLD: assert property (@(posedge clk) disable iff (rst)
        rst_req && !rst_ack |=> rst_req); // R6

    AST_ACT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid || recal_req || rst_req) |-> busy); // R7

    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R7

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid || recal_req || rst_req) |=> $stable(mode_sel)); // R8
endmodule

bind phy_rate_switcher prs_checker #(
    .CFG_AW (CFG_AW),
    .CFG_DW (CFG_DW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .cfg_valid (cfg_valid),
    .cfg_ready (cfg_ready),
    .cfg_addr  (cfg_addr),
    .cfg_data  (cfg_data),
    .pll_sel   (pll_sel),
    .recal_req (recal_req),
    .rst_req   (rst_req),
    .rst_ack   (rst_ack),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_phy_rate_switcher.sv
`timescale 1ns/1ps
module sim_phy_rate_switcher;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [1:0]  mode_sel;
    logic        cfg_valid;
    logic        cfg_ready = 1'b0;
    logic [7:0]  cfg_addr;
    logic [15:0] cfg_data;
    logic        pll_sel;
    logic        recal_req;
    logic        recal_done = 1'b0;
    logic        rst_req;
    logic        rst_ack = 1'b0;
    logic        busy;
    logic        done;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    phy_rate_switcher u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_sel(mode_sel),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .pll_sel(pll_sel), .recal_req(recal_req),
        .recal_done(recal_done), .rst_req(rst_req), .rst_ack(rst_ack),
        .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd1; reg_wdata = 8'd0;
    endtask

    task automatic rd_status(output logic [7:0] v);
        reg_addr = 2'd1;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] s;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 mode after reset", 32'(mode_sel), 32'd0);
        chk("R10 pll after reset", 32'(pll_sel), 32'd0);
        chk("R10 requests after reset", 32'({cfg_valid, recal_req, rst_req, busy, done}), 32'd0);
        rd_status(s);
        chk("R10 status after reset", 32'(s), 32'd0);
        repeat (5) @(negedge clk);
        chk("R1 idle without write", 32'({busy, cfg_valid}), 32'd0);
    endtask

    // one full speed change; optional stalls and a request during the calibration wait
    task automatic t_change(input logic [1:0] spd, input bit stall, input bit poke);
        logic [7:0] s;
        logic       old_pll;
        old_pll = pll_sel;
        wr(2'd0, {6'd0, spd});
        chk("R1 busy after write", 32'(busy), 32'd1);
        chk("R2 no word before mode", 32'(cfg_valid), 32'd0);
        @(negedge clk);
        chk("R2 mode driven", 32'(mode_sel), 32'(spd));
        for (int i = 0; i < 8; i++) begin
            if (stall && (i % 2 == 1)) begin
                cfg_ready = 1'b0;
                chk("R3 valid during stall", 32'(cfg_valid), 32'd1);
                @(negedge clk);
                chk("R3 addr held", 32'(cfg_addr), 32'(8'h40 + i));
            end
            cfg_ready = 1'b1;
            chk("R3 valid", 32'(cfg_valid), 32'd1);
            chk("R3 word addr", 32'(cfg_addr), 32'(8'h40 + i));
            chk("R3 word data", 32'(cfg_data), 32'(16'hA000 | (16'(spd) << 8) | 16'(i)));
            chk("R4 pll not yet", 32'(pll_sel), 32'(old_pll));
            @(negedge clk);
        end
        cfg_ready = 1'b0;
        chk("R3 valid drops after 8", 32'(cfg_valid), 32'd0);
        chk("R4 pll not yet after load", 32'(pll_sel), 32'(old_pll));
        @(negedge clk);
        chk("R4 pll selected", 32'(pll_sel), 32'(spd[1]));
        chk("R5 recal pulse", 32'(recal_req), 32'd1);
        @(negedge clk);
        chk("R5 recal one cycle", 32'(recal_req), 32'd0);
        if (poke) begin
            wr(2'd0, {6'd0, ~spd});
            chk("R8 mode unchanged", 32'(mode_sel), 32'(spd));
            chk("R8 still waiting", 32'({busy, rst_req, cfg_valid}), 32'b100);
        end
        repeat (2) @(negedge clk);
        chk("R5 waits for done", 32'(rst_req), 32'd0);
        recal_done = 1'b1;
        @(negedge clk);
        recal_done = 1'b0;
        chk("R6 reset requested", 32'(rst_req), 32'd1);
        repeat (2) @(negedge clk);
        chk("R6 reset held", 32'({rst_req, busy}), 32'b11);
        rst_ack = 1'b1;
        @(negedge clk);
        rst_ack = 1'b0;
        chk("R6 reset released", 32'(rst_req), 32'd0);
        rd_status(s);
        chk("R7 busy low done set", 32'(s[1:0]), 32'b10);
        chk("R10 status mode", 32'(s[5:4]), 32'(spd));
        chk("R8 error flag", 32'(s[2]), 32'(poke));
    endtask

    task automatic t_clear();
        logic [7:0] s;
        wr(2'd1, 8'h06);
        rd_status(s);
        chk("R7 R8 sticky flags cleared", 32'(s[2:1]), 32'd0);
    endtask

    task automatic t_same_speed();
        // R9: repeating 10G still walks through every step
        t_change(2'b11, 1'b0, 1'b0);
        t_change(2'b11, 1'b1, 1'b0);
    endtask

    initial begin
        t_reset();
        t_change(2'b10, 1'b1, 1'b0);
        t_change(2'b01, 1'b0, 1'b0);
        t_change(2'b00, 1'b1, 1'b1);
        t_clear();
        t_same_speed();
        t_change(2'b01, 1'b0, 1'b1);
        t_clear();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule